// File: doc/BRIEF.md
# Berger-Code Concurrent Output Checker

This block watches the data outputs of a combinational logic array while it runs, together with a few extra lines on which the array reports a check value. The check value is the number of zero bits in the data word. The array sends it bit-inverted. The checker rebuilds the zero count locally from the data. It pairs each received check line with the matching bit of that count, so a healthy pair holds complementary values. A tree of two-rail comparison cells then reduces all the pairs to one complementary pair.

An evaluation is marked by a valid strobe. On that edge the reduced pair is registered to the outputs. A non-code result sets a sticky error flag, which software-independent logic clears with a synchronous clear input. Because the result leaves as a two-rail pair, a fault inside the comparison tree itself shows up as a non-complementary output.

Top module: `berger_checker`

## Requirements
- R1: The local check value is the number of 0 bits in the K-bit data word, as an unsigned binary number of CW = ceil(log2(K+1)) bits.
- R2: The check input is expected to carry the bitwise inverse of the zero count. A check input equal to the non-inverted count is always treated as non-code.
- R3: When valid is high and the check input equals the inverse of the zero count, then after that clock edge rail_f and rail_g hold complementary values.
- R4: When valid is high and any check bit differs from the inverse of the zero count, then after that clock edge rail_f equals rail_g.
- R5: A valid evaluation with a non-code result sets err at that edge. err stays 1 through later valid code words until it is cleared.
- R6: clr high clears err at the next edge. clr takes priority over a non-code evaluation in the same cycle.
- R7: While valid is low, rail_f, rail_g and err keep their values, whatever the data and check inputs carry.
- R8: Synchronous active-high reset sets rail_f to 1, rail_g to 0 and err to 0.
- R9: With K = 1, the check width is one bit and the tree is a single cell. The checker accepts exactly the inputs whose check bit equals the data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the sticky error flag |
| valid | input | 1 | Marks a cycle whose data and check lines are to be checked |
| data | input | K | Data outputs of the array under check |
| chk_n | input | CW | Inverted zero-count check lines from the array |
| rail_f | output | 1 | Registered first rail of the result pair |
| rail_g | output | 1 | Registered second rail of the result pair |
| err | output | 1 | Sticky error flag |

## Verification
For a five-bit configuration, the bench sweeps every data word against every possible check word, and it does the same for a one-bit instance. This catches a miscounted zero total, a missing inversion, or a tree cell that lets a single wrong pair through as a valid code. The sweep also covers a padded leaf that is tied to the wrong value, which would flag good words or pass bad ones. Directed steps then target the following failures:
- a flag that drops on the next good word;
- a clear that loses to a simultaneous error;
- outputs that follow the inputs while the strobe is low.

// File: rtl/berger_pkg.sv
package berger_pkg;

  typedef struct packed {
    logic r0;
    logic r1;
  } rail_t;

  localparam rail_t RAIL_REF = '{r0: 1'b1, r1: 1'b0};

  function automatic rail_t tr_combine(input rail_t a, input rail_t b);
    rail_t y;
    y.r0 = (a.r0 & b.r0) | (a.r1 & b.r1);
    y.r1 = (a.r0 & b.r1) | (a.r1 & b.r0);
    return y;
  endfunction

  function automatic logic is_code(input rail_t p);
    return p.r0 ^ p.r1;
  endfunction

endpackage

// File: rtl/zero_counter.sv
module zero_counter #(
  parameter int K = 8,
  localparam int CW = $clog2(K + 1)
) (
  input  logic [K-1:0]  word,
  output logic [CW-1:0] zeros
);
  always_comb begin
    zeros = '0;
    for (int i = 0; i < K; i++) begin
      if (!word[i]) zeros = zeros + CW'(1);
    end
  end
endmodule

// File: rtl/two_rail_cell.sv
module two_rail_cell
  import berger_pkg::*;
(
  input  rail_t a,
  input  rail_t b,
  output rail_t y
);
  assign y = tr_combine(a, b);
endmodule

// File: rtl/two_rail_tree.sv
module two_rail_tree
  import berger_pkg::*;
#(
  parameter int N = 4,
  localparam int NL = (N < 2) ? 2 : (1 << $clog2(N)),
  localparam int NN = 2 * NL - 1
) (
  input  logic [N-1:0] p0,
  input  logic [N-1:0] p1,
  output rail_t        root
);
  rail_t node [NN];

  for (genvar i = 0; i < NL; i++) begin : g_leaf
    if (i < N) begin : g_used
      assign node[NL-1+i] = '{r0: p0[i], r1: p1[i]};
    end else begin : g_pad
      assign node[NL-1+i] = RAIL_REF;
    end
  end

  for (genvar j = 0; j < NL - 1; j++) begin : g_cell
    two_rail_cell u_cell (
      .a(node[2*j+1]),
      .b(node[2*j+2]),
      .y(node[j])
    );
  end

  assign root = node[0];
endmodule

// File: rtl/berger_checker.sv
module berger_checker
  import berger_pkg::*;
#(
  parameter int K = 8,
  localparam int CW = $clog2(K + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          valid,
  input  logic [K-1:0]  data,
  input  logic [CW-1:0] chk_n,
  output logic          rail_f,
  output logic          rail_g,
  output logic          err
);
  logic [CW-1:0] zcnt;
  rail_t         root;

  zero_counter #(.K(K)) u_count (
    .word (data),
    .zeros(zcnt)
  );

  // Each pair holds a local count bit and the matching received line.
  two_rail_tree #(.N(CW)) u_tree (
    .p0  (zcnt),
    .p1  (chk_n),
    .root(root)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rail_f <= 1'b1;
      rail_g <= 1'b0;
    end else if (valid) begin
      rail_f <= root.r0;
      rail_g <= root.r1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                          err <= 1'b0;
    else if (clr)                     err <= 1'b0;
    else if (valid && !is_code(root)) err <= 1'b1;
  end

  // R3: a matching check word gives a complementary tree result
  assert_code_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (chk_n == ~zcnt) |-> (root.r0 != root.r1));

  // R4: any mismatched check line gives a non-code tree result
  assert_noncode_R4: assert property (@(posedge clk) disable iff (rst)
    (chk_n != ~zcnt) |-> (root.r0 == root.r1));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (err && !clr) |=> err);

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> !err);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!valid && !clr) |=> ($stable(rail_f) && $stable(rail_g) && $stable(err)));

endmodule

// File: tb/tb_berger_checker.sv
module tb_berger_checker;
  localparam int K  = 5;
  localparam int CW = $clog2(K + 1);

  logic clk = 1'b0;
  logic rst, clr, valid;
  logic [K-1:0]  data;
  logic [CW-1:0] chk_n;
  logic rf, rg, err;
  logic d1, c1, rf1, rg1, err1;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  berger_checker #(.K(K)) dut (
    .clk(clk), .rst(rst), .clr(clr), .valid(valid),
    .data(data), .chk_n(chk_n),
    .rail_f(rf), .rail_g(rg), .err(err)
  );

  berger_checker #(.K(1)) dut_k1 (
    .clk(clk), .rst(rst), .clr(clr), .valid(valid),
    .data(d1), .chk_n(c1),
    .rail_f(rf1), .rail_g(rg1), .err(err1)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [K-1:0] d, input logic [CW-1:0] c,
                      input logic v, input logic cl);
    @(negedge clk);
    data = d; chk_n = c; valid = v; clr = cl;
    @(negedge clk);
    valid = 1'b0; clr = 1'b0;
  endtask

  function automatic logic [CW-1:0] zeros_of(input logic [K-1:0] d);
    return CW'(K - $countones(d));
  endfunction

  initial begin
    rst = 1'b1; clr = 1'b0; valid = 1'b0;
    data = '0; chk_n = '0; d1 = 1'b0; c1 = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: reset state
    check(rf == 1'b1 && rg == 1'b0, "R8", "rails after reset", {rf, rg}, 2);
    check(err == 1'b0, "R8", "err after reset", err, 0);

    // R1 R3 R4 R5: exhaustive data x check sweep
    for (int d = 0; d < (1 << K); d++) begin
      for (int c = 0; c < (1 << CW); c++) begin
        logic ok;
        ok = (CW'(c) == ~zeros_of(K'(d)));
        step(K'(d), CW'(c), 1'b1, 1'b0);
        check((rf != rg) == ok, ok ? "R3" : "R4", "rail complementarity",
              rf != rg, ok);
        check(err == !ok, "R5", "err after evaluation", err, !ok);
        step('0, '0, 1'b0, 1'b1);
        check(err == 1'b0, "R6", "err after clear", err, 0);
      end
    end

    // R2: non-inverted count always rejected
    for (int d = 0; d < (1 << K); d += 7) begin
      step(K'(d), zeros_of(K'(d)), 1'b1, 1'b0);
      check(rf == rg, "R2", "uninverted check rejected", rf != rg, 0);
      step('0, '0, 1'b0, 1'b1);
    end

    // R5 sticky, R7 hold
    step(5'b00000, '0, 1'b1, 1'b0);
    check(err == 1'b1, "R5", "err set by bad word", err, 1);
    begin
      logic pf, pg;
      pf = rf; pg = rg;
      step(5'b10110, ~zeros_of(5'b10110), 1'b0, 1'b0);
      check(rf == pf && rg == pg, "R7", "rails held without valid", {rf, rg}, {pf, pg});
      check(err == 1'b1, "R7", "err held without valid", err, 1);
      step(5'b00011, 3'b001, 1'b0, 1'b0);
      check(rf == pf && rg == pg, "R7", "rails held on bad idle input", {rf, rg}, {pf, pg});
    end
    step(5'b11111, ~zeros_of(5'b11111), 1'b1, 1'b0);
    check(rf != rg, "R3", "good word after error", rf != rg, 1);
    check(err == 1'b1, "R5", "err stays set on good word", err, 1);

    // R6: clear beats same-cycle error
    step(5'b01010, 3'b000, 1'b1, 1'b1);
    check(err == 1'b0, "R6", "clear priority", err, 0);
    check(rf == rg, "R4", "rails still updated with clear", rf != rg, 0);

    // R9: single-bit instance
    step('0, '0, 1'b0, 1'b1);
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 2; c++) begin
        logic ok;
        ok = (c == d);
        @(negedge clk);
        d1 = d[0]; c1 = c[0]; valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
        check((rf1 != rg1) == ok, "R9", "k1 rail complementarity", rf1 != rg1, ok);
        check(err1 == !ok, "R9", "k1 err", err1, !ok);
        step('0, '0, 1'b0, 1'b1);
      end
    end

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule